// File: doc/BRIEF.md
# Flash Controller Register Interface

This block is the software-facing register set of an embedded flash controller. A simple single-cycle bus write port and a zero-wait combinational read port reach three locations:

- **Key register.** Takes the unlock keys.
- **Control register.** Holds the operation-select bits, a start bit and a lock bit.
- **Address register.** Holds the 32-bit flash address.

The flash engine itself sits outside the block. It reports a busy level. It can also load the address register with the address it is working on.

After reset the control register is locked. To clear the lock, software writes the first key and then the second key to the key register. Any wrong value or wrong order freezes the lock until the next reset. Once unlocked, software does three things: it selects an operation, loads the address (for a page erase, the page address), and writes the start bit. When an erase is selected and the engine is idle, the block sends the engine a one-cycle start request. The start bit stays set until the engine's busy level falls.

Top module: `flash_ctl_regs`

## Requirements
- R1: After reset the control register reads 0x80 (lock set, all other bits 0), the address register reads 0, `locked` is 1 and `op_select` is 0.
- R2: Control register bit positions are: 0 program, 1 page erase, 2 mass erase, 3 reserved, 4 option-byte program, 5 option-byte erase, 6 start, 7 lock. Bit 3 and bits 31:8 always read 0. While the block is unlocked, a control write without bit 7 loads bits 0,1,2,4,5. `op_select` presents them as {5,4,2,1,0}.
- R3: Writing 0 to the lock bit has no effect. Any control write with bit 7 set relocks the block and leaves every other bit unchanged.
- R4: While the block is locked and not frozen, a key-register write of KEY_A followed by a key-register write of KEY_B clears the lock in the cycle after the second write.
- R5: While the lock waits for a key, any key write that does not match the expected key freezes the lock. After that, no key sequence clears it until reset.
- R6: While the block is locked, control writes without bit 7 are ignored and bus writes to the address register are ignored.
- R7: `start_req` pulses high for one cycle after a control write that meets all of these: the block is unlocked, bit 7 is 0, bit 6 is 1, bit 1 or bit 2 is 1, and `eng_busy` is low. No other write raises it.
- R8: The start bit is set only by a control write with bit 6 set. It is cleared the cycle after `eng_busy` falls, unless a write sets it in that same cycle. Writing 0 to it has no effect.
- R9: Bus writes to the address register are ignored while `eng_busy` is high.
- R10: `eng_addr_ld` loads `eng_addr` into the address register on the next edge, whatever the lock and busy state. If a bus write to that register happens in the same cycle, the engine load wins.
- R11: Reads are combinational from `bus_addr`. The key register and unmapped offsets read 0. Offsets are: key 0x04, control 0x10, address 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | AW | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, zero wait |
| eng_busy | input | 1 | Flash engine busy level |
| eng_addr_ld | input | 1 | Engine loads its current address |
| eng_addr | input | 32 | Address from the engine |
| op_select | output | 5 | Selected operations {opt erase, opt prog, mass, page, prog} |
| start_req | output | 1 | One-cycle erase start request |
| locked | output | 1 | Lock bit state |
| flash_addr | output | 32 | Address register contents |

## Verification
The bench builds the block with AW = 8 and with KEY_A and KEY_B overridden to values other than the defaults. This shows that the unlock comparison follows the parameters, not fixed constants. With 8-bit offsets the bench can also read unmapped locations next to the three registers.

The bench steps through several scenarios: relocking followed by a second unlock, freezing caused by a wrong key, and a reset in the middle of the run that clears the freeze. It also toggles the busy level so that start-clear, start-request suppression, address blocking and engine-load priority are each reached in isolation and in combination.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  localparam int DATA_W = 32;

  // control register bit positions (read back by software)
  localparam int B_PG   = 0;
  localparam int B_PER  = 1;
  localparam int B_MER  = 2;
  localparam int B_RSV  = 3;
  localparam int B_OPG  = 4;
  localparam int B_OER  = 5;
  localparam int B_STRT = 6;
  localparam int B_LOCK = 7;

  typedef enum logic [1:0] {
    UL_WAIT_A = 2'd0,
    UL_WAIT_B = 2'd1,
    UL_OPEN   = 2'd2,
    UL_FROZEN = 2'd3
  } unlock_st_e;

  typedef struct packed {
    logic opt_erase;
    logic opt_prog;
    logic mass;
    logic page;
    logic prog;
  } op_sel_t;
endpackage

// File: rtl/flash_unlock_fsm.sv
module flash_unlock_fsm
  import flash_ctl_pkg::*;
#(
  parameter logic [DATA_W-1:0] KEY_A = 32'h3C1F_A507,
  parameter logic [DATA_W-1:0] KEY_B = 32'hC3E0_5AF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              relock,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              locked
);
  unlock_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (relock) begin
      if (st_q != UL_FROZEN) st_d = UL_WAIT_A;
    end else if (key_wr) begin
      unique case (st_q)
        UL_WAIT_A: st_d = (key_data == KEY_A) ? UL_WAIT_B : UL_FROZEN;
        UL_WAIT_B: st_d = (key_data == KEY_B) ? UL_OPEN : UL_FROZEN;
        default:   st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= UL_WAIT_A;
    else        st_q <= st_d;
  end

  assign locked = (st_q != UL_OPEN);
endmodule

// File: rtl/flash_ctrl_reg.sv
module flash_ctrl_reg
  import flash_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       busy,
  output op_sel_t    ops,
  output logic       start,
  output logic       start_pulse
);
  logic busy_q;
  logic erase_sel;

  assign erase_sel = wdata[B_PER] | wdata[B_MER];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ops         <= '0;
      start       <= 1'b0;
      start_pulse <= 1'b0;
      busy_q      <= 1'b0;
    end else begin
      busy_q      <= busy;
      start_pulse <= wr & wdata[B_STRT] & erase_sel & ~busy;
      if (wr) begin
        ops.prog      <= wdata[B_PG];
        ops.page      <= wdata[B_PER];
        ops.mass      <= wdata[B_MER];
        ops.opt_prog  <= wdata[B_OPG];
        ops.opt_erase <= wdata[B_OER];
      end
      if (wr && wdata[B_STRT]) start <= 1'b1;
      else if (busy_q && !busy) start <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_addr_reg.sv
module flash_addr_reg
  import flash_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              locked,
  input  logic              busy,
  input  logic [DATA_W-1:0] wdata,
  input  logic              eng_ld,
  input  logic [DATA_W-1:0] eng_addr,
  output logic [DATA_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)                          addr <= '0;
    else if (eng_ld)                     addr <= eng_addr;
    else if (bus_wr && !locked && !busy) addr <= wdata;
  end
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
  import flash_ctl_pkg::*;
#(
  parameter int                AW       = 8,
  parameter logic [AW-1:0]     KEY_OFS  = 8'h04,
  parameter logic [AW-1:0]     CTRL_OFS = 8'h10,
  parameter logic [AW-1:0]     ADDR_OFS = 8'h14,
  parameter logic [DATA_W-1:0] KEY_A    = 32'h3C1F_A507,
  parameter logic [DATA_W-1:0] KEY_B    = 32'hC3E0_5AF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              eng_busy,
  input  logic              eng_addr_ld,
  input  logic [DATA_W-1:0] eng_addr,
  output logic [4:0]        op_select,
  output logic              start_req,
  output logic              locked,
  output logic [DATA_W-1:0] flash_addr
);
  logic    key_wr, ctrl_wr, addr_wr, relock, ctrl_upd;
  logic    start_bit;
  op_sel_t ops;

  assign key_wr   = bus_we && (bus_addr == KEY_OFS);
  assign ctrl_wr  = bus_we && (bus_addr == CTRL_OFS);
  assign addr_wr  = bus_we && (bus_addr == ADDR_OFS);
  assign relock   = ctrl_wr && bus_wdata[B_LOCK];
  assign ctrl_upd = ctrl_wr && !bus_wdata[B_LOCK] && !locked;

  flash_unlock_fsm #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_unlock (
    .clk      (clk),
    .rst_n    (rst_n),
    .relock   (relock),
    .key_wr   (key_wr),
    .key_data (bus_wdata),
    .locked   (locked)
  );

  flash_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (ctrl_upd),
    .wdata       (bus_wdata[7:0]),
    .busy        (eng_busy),
    .ops         (ops),
    .start       (start_bit),
    .start_pulse (start_req)
  );

  flash_addr_reg u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (addr_wr),
    .locked   (locked),
    .busy     (eng_busy),
    .wdata    (bus_wdata),
    .eng_ld   (eng_addr_ld),
    .eng_addr (eng_addr),
    .addr     (flash_addr)
  );

  assign op_select = ops;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFS) begin
      bus_rdata[B_PG]   = ops.prog;
      bus_rdata[B_PER]  = ops.page;
      bus_rdata[B_MER]  = ops.mass;
      bus_rdata[B_OPG]  = ops.opt_prog;
      bus_rdata[B_OER]  = ops.opt_erase;
      bus_rdata[B_STRT] = start_bit;
      bus_rdata[B_LOCK] = locked;
    end else if (bus_addr == ADDR_OFS) begin
      bus_rdata = flash_addr;
    end
  end
endmodule

// File: rtl/flash_ctl_regs_chk.sv
module flash_ctl_regs_chk
  import flash_ctl_pkg::*;
#(
  parameter int                AW       = 8,
  parameter logic [AW-1:0]     KEY_OFS  = 8'h04,
  parameter logic [AW-1:0]     CTRL_OFS = 8'h10,
  parameter logic [DATA_W-1:0] KEY_B    = 32'hC3E0_5AF8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              eng_busy,
  input logic              eng_addr_ld,
  input logic [DATA_W-1:0] eng_addr,
  input logic [4:0]        op_select,
  input logic              start_req,
  input logic              locked,
  input logic [DATA_W-1:0] flash_addr,
  input logic              start_bit
);
  logic busy_d;
  always_ff @(posedge clk) begin
    if (!rst_n) busy_d <= 1'b0;
    else        busy_d <= eng_busy;
  end

  logic wr_ctrl, wr_key;
  assign wr_ctrl = bus_we && (bus_addr == CTRL_OFS);
  assign wr_key  = bus_we && (bus_addr == KEY_OFS);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (locked && flash_addr == '0 && op_select == '0 && !start_bit));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CTRL_OFS) |-> (bus_rdata[31:8] == '0 && !bus_rdata[B_RSV]));

  a_r3_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[B_LOCK]) |=> locked);

  // R4 / R5: the lock only drops on a second-key write
  a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !(wr_key && bus_wdata == KEY_B)) |=> locked);

  // R6 and R9: address register protected from the bus
  a_r9_addr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    ((locked || eng_busy) && !eng_addr_ld) |=> $stable(flash_addr));

  a_r6_ops_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(op_select));

  a_r7_req_cond: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |-> ($past(wr_ctrl) && !$past(eng_busy) && !$past(locked)));

  a_r8_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_d && !eng_busy && !(wr_ctrl && bus_wdata[B_STRT])) |=> !start_bit);

  a_r10_eng_load: assert property (@(posedge clk) disable iff (!rst_n)
    eng_addr_ld |=> (flash_addr == $past(eng_addr)));
endmodule

bind flash_ctl_regs flash_ctl_regs_chk #(
  .AW(AW), .KEY_OFS(KEY_OFS), .CTRL_OFS(CTRL_OFS), .KEY_B(KEY_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
  .eng_addr_ld(eng_addr_ld), .eng_addr(eng_addr), .op_select(op_select),
  .start_req(start_req), .locked(locked), .flash_addr(flash_addr),
  .start_bit(start_bit)
);

// File: tb/flash_ctl_regs_test.sv
module flash_ctl_regs_test;
  localparam logic [31:0] KA = 32'h1357_9BDF;
  localparam logic [31:0] KB = 32'h2468_ACE0;
  localparam logic [7:0]  O_KEY = 8'h04, O_CTRL = 8'h10, O_ADDR = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h10;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        eng_busy = 1'b0;
  logic        eng_addr_ld = 1'b0;
  logic [31:0] eng_addr = '0;
  logic [4:0]  op_select;
  logic        start_req, locked;
  logic [31:0] flash_addr;

  always #2.5 clk = ~clk;

  flash_ctl_regs #(.AW(8), .KEY_A(KA), .KEY_B(KB)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_busy(eng_busy),
    .eng_addr_ld(eng_addr_ld), .eng_addr(eng_addr), .op_select(op_select),
    .start_req(start_req), .locked(locked), .flash_addr(flash_addr)
  );

  int n_cmp = 0, n_bad = 0;
  string tag = "R1";

  // behavioural reference: lock phase 0 wait first key, 1 wait second, 2 open, 3 frozen
  int          m_phase;
  bit [5:0]    m_ops;      // bits as in the control register 5:0 (bit 3 unused)
  bit          m_start, m_req, m_busy_prev;
  bit [31:0]   m_addr;

  function automatic bit m_locked();
    return m_phase != 2;
  endfunction

  function automatic bit [31:0] m_read(bit [7:0] a);
    bit [31:0] r = '0;
    if (a == O_CTRL) begin
      r[5:0] = m_ops; r[3] = 1'b0; r[6] = m_start; r[7] = m_locked();
    end else if (a == O_ADDR) r = m_addr;
    return r;
  endfunction

  task automatic model_edge();
    bit cw, kw, aw, lk;
    if (!rst_n) begin
      m_phase = 0; m_ops = '0; m_start = 0; m_req = 0; m_busy_prev = 0; m_addr = '0;
      return;
    end
    cw = bus_we && bus_addr == O_CTRL;
    kw = bus_we && bus_addr == O_KEY;
    aw = bus_we && bus_addr == O_ADDR;
    lk = m_locked();
    m_req = cw && !lk && !bus_wdata[7] && bus_wdata[6] && (bus_wdata[1] || bus_wdata[2]) && !eng_busy;
    if (cw && !lk && !bus_wdata[7]) begin
      m_ops = bus_wdata[5:0];
      m_ops[3] = 1'b0;
    end
    if (cw && !lk && !bus_wdata[7] && bus_wdata[6]) m_start = 1;
    else if (m_busy_prev && !eng_busy) m_start = 0;
    if (eng_addr_ld) m_addr = eng_addr;
    else if (aw && !lk && !eng_busy) m_addr = bus_wdata;
    if (cw && bus_wdata[7]) begin
      if (m_phase != 3) m_phase = 0;
    end else if (kw) begin
      if (m_phase == 0) m_phase = (bus_wdata == KA) ? 1 : 3;
      else if (m_phase == 1) m_phase = (bus_wdata == KB) ? 2 : 3;
    end
    m_busy_prev = eng_busy;
  endtask

  task automatic chk(string what, bit [31:0] act, bit [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    chk("locked", {31'b0, locked}, {31'b0, m_locked()});
    chk("start_req", {31'b0, start_req}, {31'b0, m_req});
    chk("flash_addr", flash_addr, m_addr);
    chk("op_select", {27'b0, op_select}, {27'b0, m_ops[5], m_ops[4], m_ops[2], m_ops[1], m_ops[0]});
    chk("bus_rdata", bus_rdata, m_read(bus_addr));
  endtask

  task automatic wr(bit [7:0] a, bit [31:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d; step(); bus_we = 0;
  endtask

  task automatic rd(bit [7:0] a);
    bus_addr = a; step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1;
    step(); step();
    rst_n = 1;
    // R1 reset contents
    tag = "R1"; rd(O_CTRL); rd(O_ADDR);
    // R6 locked: control and address writes ignored
    tag = "R6"; wr(O_CTRL, 32'h47); wr(O_ADDR, 32'hDEAD_BEEF); rd(O_CTRL); rd(O_ADDR);
    // R3 writing 0 to lock has no effect
    tag = "R3"; wr(O_CTRL, 32'h00); rd(O_CTRL);
    // R4 correct sequence
    tag = "R4"; wr(O_KEY, KA); rd(O_CTRL); wr(O_KEY, KB); rd(O_CTRL);
    // R2 field layout, reserved bit
    tag = "R2"; wr(O_CTRL, 32'h37); rd(O_CTRL); wr(O_CTRL, 32'hFFFF_FF3F & 32'hFFFF_FF3F & 32'h0000_003F);
    rd(O_CTRL); wr(O_CTRL, 32'h11); rd(O_CTRL);
    // R7 start request
    tag = "R7"; wr(O_CTRL, 32'h42); rd(O_CTRL);
    eng_busy = 1; rd(O_CTRL); wr(O_CTRL, 32'h44); rd(O_CTRL);
    // R8 start sticky until busy falls
    tag = "R8"; wr(O_CTRL, 32'h02); rd(O_CTRL);
    eng_busy = 0; rd(O_CTRL); rd(O_CTRL);
    tag = "R7"; wr(O_CTRL, 32'h41); rd(O_CTRL); wr(O_CTRL, 32'h60); rd(O_CTRL);
    eng_busy = 1; step(); eng_busy = 0; step();
    tag = "R7"; wr(O_CTRL, 32'h44); wr(O_CTRL, 32'h46); rd(O_CTRL);
    // R9 address blocked while busy
    tag = "R9"; eng_busy = 1; wr(O_ADDR, 32'h0BAD_0001); rd(O_ADDR);
    eng_busy = 0; wr(O_ADDR, 32'h0800_4000); rd(O_ADDR);
    // R10 engine load, priority over bus write
    tag = "R10"; eng_busy = 1; eng_addr_ld = 1; eng_addr = 32'h0800_4010; step();
    eng_addr = 32'h0800_4020; wr(O_ADDR, 32'h1111_2222); eng_addr_ld = 0; eng_busy = 0;
    rd(O_ADDR); eng_addr_ld = 1; eng_addr = 32'hA5A5_0000; wr(O_ADDR, 32'h5A5A_FFFF);
    eng_addr_ld = 0; rd(O_ADDR);
    // R11 key and unmapped offsets read 0
    tag = "R11"; rd(O_KEY); rd(8'h00); rd(8'h18); rd(8'hFF);
    // R3 relock then unlock again
    tag = "R3"; wr(O_CTRL, 32'hC7); rd(O_CTRL); wr(O_ADDR, 32'h1); rd(O_ADDR);
    tag = "R4"; wr(O_KEY, KA); wr(O_KEY, KB); rd(O_CTRL);
    // R5 wrong order freezes the lock
    tag = "R5"; wr(O_CTRL, 32'h80); wr(O_KEY, KB); rd(O_CTRL);
    wr(O_KEY, KA); wr(O_KEY, KB); rd(O_CTRL); wr(O_CTRL, 32'h42); rd(O_CTRL);
    wr(O_CTRL, 32'h80); wr(O_KEY, KA); wr(O_KEY, KB); rd(O_CTRL);
    // R5 reset clears the freeze; wrong second key freezes again
    tag = "R1"; rst_n = 0; step(); step(); rst_n = 1; rd(O_CTRL); rd(O_ADDR);
    tag = "R5"; wr(O_KEY, KA); wr(O_KEY, KA); rd(O_CTRL); wr(O_KEY, KA); wr(O_KEY, KB); rd(O_CTRL);
    tag = "R1"; rst_n = 0; step(); rst_n = 1; step();
    tag = "R4"; wr(O_KEY, KA); wr(O_KEY, KB); wr(O_CTRL, 32'h44); rd(O_CTRL);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule